// File: doc/BRIEF.md
# Multi-Mode Counter/Timer with Event Input

This block is a byte-addressed counter/timer of the kind found beside a small microcontroller core. Its 16-bit count is kept as a low byte and a high byte. One of four modes is chosen: a 13-bit counter, a full 16-bit counter, an 8-bit counter that reloads itself from the high byte, or two independent 8-bit counters. Each count step comes from one of three places: every system clock, a single-cycle enable from a free-running prescaler, or a falling edge seen on a synchronised external event pin.

Software writes the two count bytes, a control byte and a status byte through one byte-wide port selected by `addr`. The same `addr` selects what `rd_data` shows, with no clock delay. An overflow sets a sticky flag. The interrupt request is raised while any flag is set and the interrupt enable input is high.

Top module: `evt_timer`

## Requirements
- R1: After reset the low byte, high byte, control byte and status byte all read 0x00 and `irq` is 0. The register addresses are 0 for the low byte, 1 for the high byte, 2 for control and 3 for status.
- R2: In mode 1 (16-bit), each count step adds one to {high, low}. A step from 0xFFFF to 0x0000 sets status bit 0.
- R3: In mode 0 (13-bit), the count is {high, low[4:0]}. A step from 0x1FFF to 0x0000 sets status bit 0. Counting never changes low[7:5].
- R4: In mode 2 (8-bit reload), only the low byte counts. A step taken at 0xFF loads the low byte from the high byte in that same cycle and sets status bit 0. The high byte does not change.
- R5: In mode 3 (split), the low byte counts from the selected source, wraps from 0xFF to 0x00 and sets status bit 0. The high byte counts on clock or prescaler ticks while control bit 7 is 1, wraps the same way and sets status bit 1.
- R6: Control bit 0 is the run enable. When it is 0, the count bytes do not change in modes 0, 1 and 2.
- R7: A write to a count byte takes effect in place of any step in that cycle. In modes 0 and 1, a write to either count byte suppresses the step for the whole count.
- R8: Status flags are sticky. Writing the status register with a 0 in a flag's bit clears that flag, and writing a 1 leaves it unchanged. When an overflow and a clear fall in the same cycle, the overflow wins.
- R9: `irq` is 1 exactly when `irq_en` is 1 and at least one status flag is set.
- R10: With control bit 3 at 0, a step is taken on every clock. With control bit 3 at 1, control bits 6:5 pick the step source: 0 is one step in 12 clocks, 1 is one in 4, 2 is one in 48, and 3 is every clock in which `ext_tick` is high.
- R11: With control bit 4 at 1, the low or main count takes one step for each high-to-low transition of `evt_pin`, and rising transitions are not counted. Control bits 2:1 hold the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the register picked by `addr` |
| addr | input | 2 | Register select for both write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the register picked by `addr` |
| evt_pin | input | 1 | External event pin, asynchronous |
| ext_tick | input | 1 | Alternate tick enable for prescale selection 3 |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `evt_pin` holds each level for at least two clocks, so that every falling edge reaches the detector intact. They also assume that software does not write control and a count byte in the same cycle, since there is only one write strobe. The bench drives the pin with levels of three clocks or longer and applies one write per clock. It opens and closes each counting window with control writes, so the number of steps counted is known exactly whatever the prescaler phase is.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BYTE_W = 8;
    localparam int W13_LO = 5;
    localparam int W13    = BYTE_W + W13_LO;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        MODE_W13     = 2'd0,
        MODE_W16     = 2'd1,
        MODE_RELOAD8 = 2'd2,
        MODE_SPLIT   = 2'd3
    } tmr_mode_e;

    typedef enum logic [1:0] {
        REG_LO   = 2'd0,
        REG_HI   = 2'd1,
        REG_CTRL = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic      run_hi;
        logic [1:0] scale;
        logic      evt_mode;
        logic      use_pre;
        tmr_mode_e mode;
        logic      run;
    } ctrl_t;

    typedef struct packed {
        logic ovf_hi;
        logic ovf_lo;
    } flags_t;

    function automatic logic all_ones(input byte_t v);
        return &v;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV_A = 12,
    parameter int DIV_B = 4,
    parameter int DIV_C = 48
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] scale,
    input  logic       ext_tick,
    output logic       tick
);
    localparam int CW = (DIV_C > 1) ? $clog2(DIV_C) : 1;

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap = (int'(cnt_q) == DIV_C - 1);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (wrap) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        unique case (scale)
            2'd0:    tick = ((int'(cnt_q) % DIV_A) == DIV_A - 1);
            2'd1:    tick = ((int'(cnt_q) % DIV_B) == DIV_B - 1);
            2'd2:    tick = wrap;
            default: tick = ext_tick;
        endcase
    end

endmodule

// File: rtl/tmr_fall_det.sv
module tmr_fall_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], pin};
    end

    assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tmr_mode_e mode,
    input  logic      tick_lo,
    input  logic      tick_hi,
    input  logic      wr_lo,
    input  logic      wr_hi,
    input  byte_t     wr_data,
    output byte_t     tl,
    output byte_t     th,
    output logic      ev_lo,
    output logic      ev_hi
);
    byte_t tl_n, th_n;
    logic [W13-1:0]      s13;
    logic [2*BYTE_W-1:0] s16;
    logic                any_wr;

    assign s13    = {th, tl[W13_LO-1:0]} + 1'b1;
    assign s16    = {th, tl} + 1'b1;
    assign any_wr = wr_lo | wr_hi;

    always_comb begin
        tl_n  = tl;
        th_n  = th;
        ev_lo = 1'b0;
        ev_hi = 1'b0;
        unique case (mode)
            MODE_W13: if (tick_lo && !any_wr) begin
                {th_n, tl_n[W13_LO-1:0]} = s13;
                ev_lo = all_ones(th) && (&tl[W13_LO-1:0]);
            end
            MODE_W16: if (tick_lo && !any_wr) begin
                {th_n, tl_n} = s16;
                ev_lo = all_ones(th) && all_ones(tl);
            end
            MODE_RELOAD8: if (tick_lo && !wr_lo) begin
                if (all_ones(tl)) begin
                    tl_n  = th;
                    ev_lo = 1'b1;
                end else begin
                    tl_n = tl + 1'b1;
                end
            end
            default: begin
                if (tick_lo && !wr_lo) begin
                    tl_n  = tl + 1'b1;
                    ev_lo = all_ones(tl);
                end
                if (tick_hi && !wr_hi) begin
                    th_n  = th + 1'b1;
                    ev_hi = all_ones(th);
                end
            end
        endcase
        if (wr_lo) tl_n = wr_data;
        if (wr_hi) th_n = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tl <= '0;
            th <= '0;
        end else begin
            tl <= tl_n;
            th <= th_n;
        end
    end

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import tmr_pkg::*;
#(
    parameter int DIV_A       = 12,
    parameter int DIV_B       = 4,
    parameter int DIV_C       = 48,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       evt_pin,
    input  logic       ext_tick,
    input  logic       irq_en,
    output logic       irq
);
    ctrl_t     ctrl_q;
    flags_t    flags_q;
    byte_t     tl, th;
    logic      pre_tick, fall, base_tick;
    logic      tick_lo, tick_hi, ev_lo, ev_hi;
    logic      wr_lo, wr_hi, wr_ctrl, wr_stat;
    logic      run_w;
    tmr_mode_e mode_w;

    assign run_w   = ctrl_q.run;
    assign mode_w  = ctrl_q.mode;
    assign wr_lo   = wr_en && (addr == REG_LO);
    assign wr_hi   = wr_en && (addr == REG_HI);
    assign wr_ctrl = wr_en && (addr == REG_CTRL);
    assign wr_stat = wr_en && (addr == REG_STAT);

    tmr_prescale #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_pre (
        .clk(clk), .rst(rst), .scale(ctrl_q.scale),
        .ext_tick(ext_tick), .tick(pre_tick)
    );

    tmr_fall_det #(.STAGES(SYNC_STAGES)) u_fall (
        .clk(clk), .rst(rst), .pin(evt_pin), .fall(fall)
    );

    assign base_tick = ctrl_q.use_pre ? pre_tick : 1'b1;
    assign tick_lo   = ctrl_q.run & (ctrl_q.evt_mode ? fall : base_tick);
    assign tick_hi   = (ctrl_q.mode == MODE_SPLIT) & ctrl_q.run_hi & base_tick;

    tmr_count_core u_core (
        .clk(clk), .rst(rst), .mode(ctrl_q.mode),
        .tick_lo(tick_lo), .tick_hi(tick_hi),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
        .tl(tl), .th(th), .ev_lo(ev_lo), .ev_hi(ev_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            flags_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data);
            flags_q.ovf_lo <= ev_lo | (flags_q.ovf_lo & ~(wr_stat & ~wr_data[0]));
            flags_q.ovf_hi <= ev_hi | (flags_q.ovf_hi & ~(wr_stat & ~wr_data[1]));
        end
    end

    always_comb begin
        unique case (addr)
            REG_LO:   rd_data = tl;
            REG_HI:   rd_data = th;
            REG_CTRL: rd_data = ctrl_q;
            default:  rd_data = {{(BYTE_W-2){1'b0}}, flags_q};
        endcase
    end

    assign irq = irq_en & (flags_q.ovf_lo | flags_q.ovf_hi);

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      wr_en,
    input logic [1:0] addr,
    input logic [7:0] wr_data,
    input logic      run,
    input tmr_mode_e mode,
    input logic      tick_lo,
    input byte_t     tl,
    input byte_t     th,
    input flags_t    flags,
    input logic      irq_en,
    input logic      irq
);
    // R2: a full 16-bit count wraps to zero and raises the flag
    a_r2_wrap16: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_W16 && tick_lo && (&{th, tl}) && !wr_en)
        |=> (tl == '0 && th == '0 && flags.ovf_lo));

    // R3: counting in 13-bit mode leaves low[7:5] alone
    a_r3_upper_kept: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_W13 && !(wr_en && addr == REG_LO))
        |=> (tl[BYTE_W-1:W13_LO] == $past(tl[BYTE_W-1:W13_LO])));

    // R4: reload from the high byte on wrap
    a_r4_reload: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RELOAD8 && tick_lo && (&tl) && !wr_en)
        |=> (tl == $past(th) && th == $past(th) && flags.ovf_lo));

    // R6: stopped counter holds in non-split modes
    a_r6_stopped_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_en && mode != MODE_SPLIT)
        |=> ($stable(tl) && $stable(th)));

    // R7: a byte write lands unchanged
    a_r7_write_wins: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == REG_LO) |=> (tl == $past(wr_data)));

    // R8: flag stays set unless cleared by a zero write
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flags.ovf_lo && !(wr_en && addr == REG_STAT && !wr_data[0]))
        |=> flags.ovf_lo);

    // R9: a request only rises while enabled
    a_r9_irq_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> irq_en);

endmodule

bind evt_timer tmr_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .run(run_w), .mode(mode_w), .tick_lo(tick_lo), .tl(tl), .th(th),
    .flags(flags_q), .irq_en(irq_en), .irq(irq)
);

// File: tb/tb_evt_timer.sv
module tb_evt_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       evt_pin = 1'b1;
    logic       ext_tick = 1'b0;
    logic       irq_en = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    evt_timer dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .evt_pin(evt_pin), .ext_tick(ext_tick),
        .irq_en(irq_en), .irq(irq)
    );

    // {ctrl, hi, lo, steps, exp_hi, exp_lo, exp_stat}
    localparam logic [55:0] VEC [9] = '{
        {8'h03, 8'hFF, 8'hFE, 8'd3, 8'h00, 8'h01, 8'h01},
        {8'h03, 8'h12, 8'h34, 8'd5, 8'h12, 8'h39, 8'h00},
        {8'h03, 8'h00, 8'hFF, 8'd1, 8'h01, 8'h00, 8'h00},
        {8'h01, 8'hFF, 8'hFF, 8'd2, 8'h00, 8'hE1, 8'h01},
        {8'h01, 8'h00, 8'hBF, 8'd1, 8'h01, 8'hA0, 8'h00},
        {8'h05, 8'hF0, 8'hFD, 8'd5, 8'hF0, 8'hF2, 8'h01},
        {8'h05, 8'h80, 8'h10, 8'd3, 8'h80, 8'h13, 8'h00},
        {8'h07, 8'h55, 8'hFE, 8'd2, 8'h55, 8'h00, 8'h01},
        {8'h87, 8'hFE, 8'h00, 8'd4, 8'h02, 8'h04, 8'h02}
    };

    function automatic string mode_tag(input logic [7:0] c);
        case (c[2:1])
            2'd0:    return "R3";
            2'd1:    return "R2";
            2'd2:    return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic window(input logic [7:0] c, input int n);
        wr(2'd2, c);
        idle(n - 1);
        wr(2'd2, c & 8'h7E);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        irq_en = 1'b1;
        idle(1);

        // R1: reset state
        rd_chk("R1", 2'd0, 8'h00);
        rd_chk("R1", 2'd1, 8'h00);
        rd_chk("R1", 2'd2, 8'h00);
        rd_chk("R1", 2'd3, 8'h00);
        chk("R1", {7'd0, irq}, 8'h00);
        irq_en = 1'b0;

        // table of mode vectors, every-clock stepping
        for (int i = 0; i < 9; i++) begin
            logic [7:0] c, h, l, n, eh, el, es;
            {c, h, l, n, eh, el, es} = VEC[i];
            wr(2'd3, 8'h00);
            wr(2'd0, l);
            wr(2'd1, h);
            window(c, int'(n));
            rd_chk(mode_tag(c), 2'd1, eh);
            rd_chk(mode_tag(c), 2'd0, el);
            rd_chk(mode_tag(c), 2'd3, es);
        end

        // R6: stopped counter holds
        wr(2'd2, 8'h02);
        wr(2'd0, 8'h05);
        wr(2'd1, 8'h00);
        idle(10);
        rd_chk("R6", 2'd0, 8'h05);

        // R7: write replaces the step
        wr(2'd0, 8'h10);
        wr(2'd2, 8'h03);
        idle(2);
        wr(2'd0, 8'h40);
        rd_chk("R7", 2'd0, 8'h40);
        wr(2'd2, 8'h02);
        rd_chk("R7", 2'd0, 8'h41);

        // R8: overflow and clear in the same cycle, overflow wins
        wr(2'd3, 8'h00);
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'h03);
        wr(2'd3, 8'h00);
        wr(2'd2, 8'h02);
        rd_chk("R8", 2'd3, 8'h01);
        rd_chk("R8", 2'd0, 8'h01);
        wr(2'd3, 8'h01);
        rd_chk("R8", 2'd3, 8'h01);

        // R9: interrupt gating
        irq_en = 1'b0; #1;
        chk("R9", {7'd0, irq}, 8'h00);
        irq_en = 1'b1; #1;
        chk("R9", {7'd0, irq}, 8'h01);
        wr(2'd3, 8'h00);
        rd_chk("R8", 2'd3, 8'h00);
        chk("R9", {7'd0, irq}, 8'h00);
        irq_en = 1'b0;

        // R10: prescaled sources over exact windows
        wr(2'd0, 8'h00); window(8'h0B, 96); rd_chk("R10", 2'd0, 8'd8);
        wr(2'd0, 8'h00); window(8'h2B, 96); rd_chk("R10", 2'd0, 8'd24);
        wr(2'd0, 8'h00); window(8'h4B, 96); rd_chk("R10", 2'd0, 8'd2);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h6B);
        ext_tick = 1'b1; idle(5);
        ext_tick = 1'b0; idle(3);
        wr(2'd2, 8'h6A);
        rd_chk("R10", 2'd0, 8'd5);

        // R11: falling edges of the event pin
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h13);
        for (int k = 0; k < 5; k++) begin
            evt_pin = 1'b0; idle(3);
            evt_pin = 1'b1; idle(3);
        end
        idle(4);
        wr(2'd2, 8'h12);
        rd_chk("R11", 2'd0, 8'd5);
        rd_chk("R11", 2'd1, 8'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule